// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a PHY link. Software places one 32-bit management word in the block. The word holds the start code, the operation, the PHY address, the register address, the turnaround code and 16 data bits. The block then sends a full serial frame on the MDC clock and MDIO data lines. For a read, the block stops driving MDIO during turnaround and data. It then collects the 16 bits the PHY returns and stores them in the low half of that same word, where software reads them back.

An enable input must be high for the port to work. The idle output shows whether a frame is in flight. A 2-bit divisor field sets MDC to the system clock divided by 8, 16, 32 or 64. Software picks the divisor so MDC stays in range for the bus clock: /8 below 20 MHz, /16 below 40 MHz, /32 below 80 MHz, and /64 above that.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdioOe is 0 and mgmtWord reads 0. While idle, mdc and mdioOe stay 0.
- R2: A write is accepted when wrEn, portEn and idle are all 1 on a clock edge. An accepted write loads wrData into mgmtWord. Idle drops from the next cycle and stays low for exactly 64*N system clock cycles, where N is the MDC divisor.
- R3: A write is ignored when portEn is 0 or a frame is in progress. In that case mgmtWord, the running frame and its length are unchanged.
- R4: Each frame is 64 bit times long. It starts with 32 preamble ones, then sends mgmtWord bits 31 down to 0, most significant bit first. Bits 31:30 hold the start code, 29:28 the operation, 27:23 the PHY address, 22:18 the register address, 17:16 the turnaround and 15:0 the data.
- R5: MDIO changes only when MDC falls. The PHY samples it on the rising MDC edge.
- R6: When mgmtWord[29:28] is 2'b10 (read), mdioOe is 0 for the last 18 bit times. These are the turnaround and the 16 data bits. Any other operation code drives all 64 bit times.
- R7: On a read, mdioIn is sampled on each rising MDC edge of the last 16 bit times. The samples go into mgmtWord[15:0], most significant bit first. Bits 31:16 stay as written.
- R8: mdc has period N system clocks with equal high and low halves. N is 8, 16, 32 or 64 for divSel 0, 1, 2 or 3. divSel is latched when a write is accepted, so later changes do not affect the running frame.
- R9: If portEn drops while a frame runs, the frame stops. On the next cycle idle is 1 and mdc and mdioOe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEn | input | 1 | Management port enable |
| wrEn | input | 1 | Write strobe for the management word |
| wrData | input | 32 | Management word to send |
| divSel | input | 2 | MDC divisor select (8 << divSel) |
| mgmtWord | output | 32 | Management word readback, with read data merged in |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen from the line |

## Verification
A write that arrives while a frame is already shifting lands in the same cycle as the sequencer's bit advance, and possibly its data capture. The bench provokes this by issuing a second write with a different word, or by changing divSel, well inside a running frame. It then checks that the frame length, the bit stream and the final readback all still match the first word and the first divisor. Randomized read and write frames at every divisor are compared bit by bit against a bench model of the frame, with a PHY model that drives known data in the read window.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // operation code that turns the line around for PHY data
  localparam logic [1:0] OP_READ = 2'b10;

  // strobes from the sequencer to the word datapath
  typedef struct packed {
    logic load;     // accept a new management word
    logic capture;  // store mdioIn into the data field
    logic drive;    // master owns the MDIO line this bit time
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_mgmt_mdcgen.sv
module mdio_mgmt_mdcgen #(
  parameter int BASE_DIV = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             stop,
  input  logic [SEL_W-1:0] divSel,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  localparam int BASE_HALF = BASE_DIV / 2;
  localparam int MAX_HALF  = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_HALF);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W:0]   halfLen;
  logic [CNT_W:0]   halfLast;
  logic             tick;

  assign halfLen  = (CNT_W+1)'(BASE_HALF) << divSel;
  assign halfLast = halfLen - 1'b1;
  assign tick     = run && !stop && ({1'b0, divCnt} == halfLast);
  assign riseTick = tick && !mdc;
  assign fallTick = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (!run || stop) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      mdc    <= ~mdc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R8: each mdc half lasts the selected half period
  assert_half_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    (run && !stop && !$stable(mdc)) |-> ($past(divCnt) == halfLast[CNT_W-1:0]));

endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int WORD_W       = 32,
  parameter int DATA_W       = 16,
  parameter int SEL_W        = 2,
  localparam int FRAME_BITS  = PREAMBLE_LEN + WORD_W,
  localparam int IDX_W       = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             portEn,
  input  logic [SEL_W-1:0] divSel,
  input  logic             isRead,
  input  logic             riseTick,
  input  logic             fallTick,
  output logic             busy,
  output logic             stop,
  output logic [SEL_W-1:0] divSelQ,
  output logic [IDX_W-1:0] bitIdx,
  output mdioStrobe_t      strobe
);
  localparam int REL_START = FRAME_BITS - DATA_W - 2;
  localparam int CAP_START = FRAME_BITS - DATA_W;
  localparam int LAST_BIT  = FRAME_BITS - 1;

  logic load;
  logic done;

  assign load = wrEn && portEn && !busy;
  assign stop = busy && !portEn;
  assign done = fallTick && (bitIdx == IDX_W'(LAST_BIT));

  always_comb begin
    strobe.load    = load;
    strobe.capture = riseTick && portEn && isRead && (bitIdx >= IDX_W'(CAP_START));
    strobe.drive   = busy && !(isRead && (bitIdx >= IDX_W'(REL_START)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
      divSelQ <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      bitIdx  <= '0;
      divSelQ <= divSel;
    end else if (stop || done) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
    end else if (fallTick) begin
      bitIdx  <= bitIdx + 1'b1;
    end
  end

  // R4: a falling mdc moves the frame one bit forward or ends it
  assert_bit_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && portEn && fallTick) |=> (!busy || bitIdx == $past(bitIdx) + 1'b1));

  // R2: an accepted word starts the frame at its first bit
  assert_start_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (busy && bitIdx == '0));

endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int WORD_W       = 32,
  parameter int DATA_W       = 16,
  localparam int FRAME_BITS  = PREAMBLE_LEN + WORD_W,
  localparam int IDX_W       = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wrData,
  input  mdioStrobe_t       strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              mdioIn,
  output logic [WORD_W-1:0] word,
  output logic              isRead,
  output logic              mdioOut
);
  localparam int LAST_BIT = FRAME_BITS - 1;
  localparam int WPOS_W   = $clog2(WORD_W);
  localparam int DPOS_W   = $clog2(DATA_W);
  localparam int OP_HI    = WORD_W - 3;

  logic [IDX_W-1:0]  fromEnd;
  logic [WPOS_W-1:0] wordPos;
  logic [DPOS_W-1:0] dataPos;
  logic              frameBit;

  assign fromEnd  = IDX_W'(LAST_BIT) - bitIdx;
  assign wordPos  = fromEnd[WPOS_W-1:0];
  assign dataPos  = fromEnd[DPOS_W-1:0];
  assign isRead   = (word[OP_HI -: 2] == OP_READ);
  assign frameBit = (bitIdx < IDX_W'(PREAMBLE_LEN)) ? 1'b1 : word[wordPos];
  assign mdioOut  = strobe.drive && frameBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word <= '0;
    end else if (strobe.load) begin
      word <= wrData;
    end else if (strobe.capture) begin
      word[dataPos] <= mdioIn;
    end
  end

  // R7: capture only ever touches the data field
  assert_header_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(word[WORD_W-1:DATA_W]));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int WORD_W       = 32,
  parameter int DATA_W       = 16,
  parameter int BASE_DIV     = 8,
  parameter int SEL_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SEL_W-1:0]  divSel,
  output logic [WORD_W-1:0] mgmtWord,
  output logic              idle,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int FRAME_BITS = PREAMBLE_LEN + WORD_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic             busy;
  logic             stop;
  logic             isRead;
  logic             riseTick;
  logic             fallTick;
  logic [SEL_W-1:0] divSelQ;
  logic [IDX_W-1:0] bitIdx;
  mdioStrobe_t      strobe;

  mdio_mgmt_seq #(
    .PREAMBLE_LEN(PREAMBLE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portEn(portEn), .divSel(divSel),
    .isRead(isRead), .riseTick(riseTick), .fallTick(fallTick), .busy(busy),
    .stop(stop), .divSelQ(divSelQ), .bitIdx(bitIdx), .strobe(strobe)
  );

  mdio_mgmt_mdcgen #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_mdcgen (
    .clk(clk), .rstN(rstN), .run(busy), .stop(stop), .divSel(divSelQ),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_mgmt_dp #(
    .PREAMBLE_LEN(PREAMBLE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe), .bitIdx(bitIdx),
    .mdioIn(mdioIn), .word(mgmtWord), .isRead(isRead), .mdioOut(mdioOut)
  );

  assign idle   = !busy;
  assign mdioOe = strobe.drive;

  // R1: nothing is driven toward the PHY between frames
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!mdc && !mdioOe));

  // R2: an accepted write clears idle on the next cycle
  assert_idle_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portEn && idle) |=> !idle);

  // R3: while a frame runs the word header cannot be replaced
  assert_word_hold_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> $stable(mgmtWord[WORD_W-1:DATA_W]));

  // R5: inside a frame the data line moves only with a falling mdc
  assert_mdio_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !$past(idle) && !$stable(mdioOut)) |-> $fell(mdc));

  // R9: dropping the enable ends the frame at once
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !portEn) |=> (idle && !mdc && !mdioOe));

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  divSel = '0;
  logic [31:0] mgmtWord;
  logic        idle, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  int cnt;
  logic outs [64];
  logic oes  [64];
  logic preRise [64];

  always #10 clk = ~clk;

  mdio_mgmt_master u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .wrEn(wrEn), .wrData(wrData),
    .divSel(divSel), .mgmtWord(mgmtWord), .idle(idle), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expCycles(input logic [1:0] sel);
    return 64 * (8 << sel);
  endfunction

  function automatic logic expBit(input logic [31:0] w, input int k);
    return (k < 32) ? 1'b1 : w[63-k];
  endfunction

  function automatic logic expOe(input logic [31:0] w, input int k);
    return !((w[29:28] == 2'b10) && (k >= 46));
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] w, input logic [15:0] phy);
    return (w[29:28] == 2'b10) ? {w[31:16], phy} : w;
  endfunction

  function automatic logic [31:0] mkWord(input bit rd);
    logic [31:0] w;
    w[31:30] = 2'b01;
    w[29:28] = rd ? 2'b10 : 2'b01;
    w[27:23] = 5'($urandom);
    w[22:18] = 5'($urandom);
    w[17:16] = 2'b10;
    w[15:0]  = 16'($urandom);
    return w;
  endfunction

  // midAct: 0 none, 1 second write mid-frame, 2 divisor change mid-frame
  task automatic runFrame(input logic [31:0] w, input logic [1:0] sel,
                          input logic [15:0] phy, input int midAct);
    int bitErr, oeErr, holdErr;
    @(negedge clk);
    divSel = sel; wrData = w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    fork
      begin
        cnt = 0;
        while (!idle) begin cnt++; @(negedge clk); end
      end
      begin
        for (int k = 0; k < 64; k++) begin
          @(posedge mdc); #1;
          outs[k] = mdioOut; oes[k] = mdioOe;
          if (k < 63) begin
            @(negedge mdc); #1;
            preRise[k+1] = mdioOut;
            mdioIn = (k + 1 >= 48) ? phy[15-(k+1-48)] : 1'b1;
          end
        end
      end
      begin
        if (midAct == 1) begin
          repeat (150) @(negedge clk);
          wrData = ~w; wrEn = 1'b1;
          @(negedge clk);
          wrEn = 1'b0;
        end else if (midAct == 2) begin
          repeat (150) @(negedge clk);
          divSel = ~sel;
        end
      end
    join
    mdioIn = 1'b1;
    bitErr = 0; oeErr = 0; holdErr = 0;
    for (int k = 0; k < 64; k++) begin
      if (oes[k] !== expOe(w, k)) oeErr++;
      if (expOe(w, k) && outs[k] !== expBit(w, k)) bitErr++;
      if (k > 0 && expOe(w, k) && preRise[k] !== outs[k]) holdErr++;
    end
    chk(bitErr == 0, "R4 frame bit stream", bitErr, 0);
    chk(oeErr == 0, "R6 output enable pattern", oeErr, 0);
    chk(holdErr == 0, "R5 mdio held across rising mdc", holdErr, 0);
    chk(cnt == expCycles(sel), "R2 R8 frame length", cnt, expCycles(sel));
    chk(mgmtWord === expWord(w, phy), "R7 R3 word readback", mgmtWord, expWord(w, phy));
    chk(!mdc && !mdioOe, "R1 quiet after frame", {mdc, mdioOe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(idle === 1'b1 && mdc === 1'b0 && mdioOe === 1'b0, "R1 reset outputs",
        {idle, mdc, mdioOe}, 32'h4);
    chk(mgmtWord === 32'h0, "R1 reset word", mgmtWord, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: write with port disabled is ignored
    wrData = 32'h5a5a_1234; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk(idle === 1'b1, "R3 disabled write keeps idle", idle, 1);
    chk(mgmtWord === 32'h0, "R3 disabled write keeps word", mgmtWord, 0);
    portEn = 1'b1;

    // directed: read and write at every divisor
    for (int s = 0; s < 4; s++) begin
      runFrame(mkWord(1'b1), 2'(s), 16'($urandom), 0);
      runFrame(mkWord(1'b0), 2'(s), 16'h0, 0);
    end
    // all-ones and all-zeros read data corners
    runFrame(mkWord(1'b1), 2'd0, 16'hffff, 0);
    runFrame(mkWord(1'b1), 2'd0, 16'h0000, 0);

    // R3: second write during a frame; R8: divisor change during a frame
    runFrame(mkWord(1'b1), 2'd1, 16'($urandom), 1);
    runFrame(mkWord(1'b0), 2'd0, 16'h0, 1);
    runFrame(mkWord(1'b1), 2'd0, 16'($urandom), 2);

    // random mix
    for (int i = 0; i < 6; i++)
      runFrame(mkWord(1'($urandom)), 2'($urandom % 3), 16'($urandom), 0);

    // R9: enable dropped mid-frame
    w = mkWord(1'b0);
    @(negedge clk);
    divSel = 2'd0; wrData = w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (100) @(negedge clk);
    chk(idle === 1'b0, "R9 frame running before abort", idle, 0);
    portEn = 1'b0;
    @(negedge clk);
    chk(idle === 1'b1 && mdc === 1'b0 && mdioOe === 1'b0, "R9 abort state",
        {idle, mdc, mdioOe}, 32'h4);
    wrData = ~w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    chk(idle === 1'b1 && mgmtWord === w, "R3 write ignored after abort", mgmtWord, w);
    portEn = 1'b1;
    runFrame(mkWord(1'b1), 2'd0, 16'hA5C3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule